// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Controller

This block is the digital control that sits around an analog voltage comparator. The comparator's one-bit decision enters on `cmpIn` and passes through a flop synchronizer. A level-select bit can invert it. It is then shown to software as a read-only result bit. The result is held at 0 for a programmable stabilization period after the comparator is switched on. That period is counted in clock cycles and loaded from a count register.

Interrupts are generated by comparing against a snapshot, not by watching an edge. Every read of the status register copies the current result into an internal latch. Once interrupts are armed, any difference between that latch and the live result sets a sticky flag, and the flag drives the interrupt line. The arming itself is deferred: setting the interrupt-enable bit only arms the logic at the next status read. Clearing the enable bit disarms it at once. The flag shares the status register with the result. The read that software does before clearing the flag therefore also refreshes the snapshot, and detection re-arms for the next change.

Register map (`regAddr`): address 0 is the status/control register, and address 1 holds the stabilization count. The count sits in the low `CNT_W` bits, and reads of it are zero-extended.

Top module: `cmp_change_irq`

## Requirements
- R1: After reset every register bit reads 0 at both addresses and `irqOut` is 0.
- R2: Writing address 0 with bit 0 (comparator on) set while it was clear starts a stabilization count of N, where N is the value held at address 1. For the first N cycles after that write the result bit (address 0, bit 3) reads 0. From the N-th cycle on, it shows the comparison level.
- R3: A change on `cmpIn` reaches the result bit two clock cycles later, through a two-stage synchronizer.
- R4: Bit 2 of address 0 (level select) inverts the result: with it set, the result bit reads 1 when `cmpIn` is 0.
- R5: Each read of address 0 (`regRd` high with `regAddr` 0) copies the result bit into the internal snapshot latch. An armed block whose live result equals that snapshot raises no flag.
- R6: Setting bit 1 of address 0 (interrupt enable) does not arm detection. Detection is armed by the first read of address 0 that follows. Result changes before that read set no flag.
- R7: While armed, a difference between the snapshot and the live result sets the sticky flag (address 0, bit 4) one cycle later. The flag drives `irqOut`, which is high exactly when the flag is set and the block is armed.
- R8: Writing 0 to the flag bit clears it only if address 0 was read while the flag was 1, with no write to address 0 in between. A write of 0 without that read leaves the flag set, and a write of 1 to the flag bit has no effect.
- R9: A write to address 0 with the interrupt enable bit 0 disarms the block in that cycle, so `irqOut` is 0 afterwards even while the flag stays set. Re-enabling requires a fresh status read to arm again.
- R10: With the comparator-on bit clear, the result bit reads 0 whatever `cmpIn` is. The count at address 1 reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmpIn | input | 1 | Analog comparator decision, asynchronous |
| regAddr | input | 1 | Register select: 0 status/control, 1 stabilization count |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (a status read has side effects) |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data of the selected register, combinational |
| irqOut | output | 1 | Interrupt request level |

## Verification
The change detector is exercised with several input sequences:
- a change before the arming read, which separates "enable written" from "armed";
- a steady input after a snapshot read, which must stay quiet;
- a change after the snapshot, which must fire;
- a change in the other direction after the clearing read, which shows that the snapshot is refreshed rather than pinned to one edge.

Flag clearing is tried three ways: without a prior read, with a written 1, and after a read. Together these separate the read-then-clear rule from a plain write-to-clear. The timer is checked at the last masked cycle and at the first valid cycle, and the polarity bit is flipped with a steady input.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  // register addresses
  localparam logic STAT_ADDR = 1'b0;
  localparam logic CNT_ADDR  = 1'b1;

  // status/control register bit positions
  localparam int BIT_ON  = 0;
  localparam int BIT_IE  = 1;
  localparam int BIT_POL = 2;
  localparam int BIT_RES = 3;
  localparam int BIT_FLG = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTimer;
    logic capture;
    logic cmpOn;
    logic polSel;
  } dpStrobe_t;

endpackage

// File: rtl/cmp_irq_dpath.sv
module cmp_irq_dpath
  import cmp_irq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] convCount,
  output logic             resultBit,
  output logic             mismatch
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       timerQ;
  logic                   latchQ;
  logic                   levelNow;

  // synchronizer chain, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= cmpIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  // stabilization timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timerQ <= '0;
    else if (strb.loadTimer)  timerQ <= convCount;
    else if (!strb.cmpOn)     timerQ <= '0;
    else if (timerQ != '0)    timerQ <= timerQ - 1'b1;
  end

  assign levelNow  = syncQ[LAST] ^ strb.polSel;
  assign resultBit = strb.cmpOn && (timerQ == '0) && levelNow;

  // snapshot latch refreshed on every status read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= 1'b0;
    else if (strb.capture) latchQ <= resultBit;
  end

  assign mismatch = latchQ ^ resultBit;

  // R2
  timer_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTimer && convCount != '0) |=> !resultBit);

  // R5
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (latchQ == $past(resultBit)));

  // R10
  off_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmpOn |-> !resultBit);

endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              resultBit,
  input  logic              mismatch,
  output dpStrobe_t         strb,
  output logic [CNT_W-1:0]  convCount,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  logic onQ, ieQ, polQ, armQ, flagQ, seenQ;
  logic [CNT_W-1:0] cntQ;
  logic statWr, statRd, cntWr;
  logic flagSet, flagClr;
  logic [DATA_W-1:0] statWord;

  assign statWr = regWr && (regAddr == STAT_ADDR);
  assign cntWr  = regWr && (regAddr == CNT_ADDR);
  assign statRd = regRd && (regAddr == STAT_ADDR);

  // control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onQ  <= 1'b0;
      ieQ  <= 1'b0;
      polQ <= 1'b0;
    end else if (statWr) begin
      onQ  <= wrData[BIT_ON];
      ieQ  <= wrData[BIT_IE];
      polQ <= wrData[BIT_POL];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cntQ <= '0;
    else if (cntWr) cntQ <= wrData[CNT_W-1:0];
  end

  // internal arm: set by a status read while enabled, dropped with enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          armQ <= 1'b0;
    else if (statWr && !wrData[BIT_IE]) armQ <= 1'b0;
    else if (!ieQ)                      armQ <= 1'b0;
    else if (statRd)                    armQ <= 1'b1;
  end

  // read-as-one tracker for flag clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                seenQ <= 1'b0;
    else if (statWr)          seenQ <= 1'b0;
    else if (statRd && flagQ) seenQ <= 1'b1;
  end

  assign flagSet = armQ && mismatch;
  assign flagClr = statWr && !wrData[BIT_FLG] && seenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagQ <= 1'b0;
    else if (flagSet) flagQ <= 1'b1;
    else if (flagClr) flagQ <= 1'b0;
  end

  always_comb begin
    strb.loadTimer = statWr && wrData[BIT_ON] && !onQ;
    strb.capture   = statRd;
    strb.cmpOn     = onQ;
    strb.polSel    = polQ;
  end

  assign convCount = cntQ;

  always_comb begin
    statWord          = '0;
    statWord[BIT_ON]  = onQ;
    statWord[BIT_IE]  = ieQ;
    statWord[BIT_POL] = polQ;
    statWord[BIT_RES] = resultBit;
    statWord[BIT_FLG] = flagQ;
  end

  assign rdData = (regAddr == STAT_ADDR) ? statWord : DATA_W'(cntQ);
  assign irqOut = flagQ && armQ;

  // R6
  arm_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armQ) |-> $past(statRd));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && mismatch) |=> flagQ);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !statWr) |=> flagQ);

  // R8
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(seenQ));

  // R9
  ie_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !wrData[BIT_IE]) |=> !irqOut);

endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
  import cmp_irq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpIn,
  input  logic              regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  dpStrobe_t        strb;
  logic [CNT_W-1:0] convCount;
  logic             resultBit;
  logic             mismatch;

  cmp_irq_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .wrData    (wrData),
    .resultBit (resultBit),
    .mismatch  (mismatch),
    .strb      (strb),
    .convCount (convCount),
    .rdData    (rdData),
    .irqOut    (irqOut)
  );

  cmp_irq_dpath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cmpIn     (cmpIn),
    .strb      (strb),
    .convCount (convCount),
    .resultBit (resultBit),
    .mismatch  (mismatch)
  );

endmodule

// File: tb/cmp_change_irq_bench.sv
`timescale 1ns/1ps
module cmp_change_irq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmpIn = 1'b0;
  logic       regAddr = 1'b0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cmp_change_irq u_cmp_change_irq (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regAddr = 1'b0;
  endtask

  task automatic rdReg(input logic a);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0; regAddr = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic resBit();
    return rdData[3];
  endfunction

  function automatic logic flgBit();
    return rdData[4];
  endfunction

  task automatic t_reset();
    regAddr = 1'b0; #0.1;
    check("R1 status", rdData, 8'h00);
    regAddr = 1'b1; #0.1;
    check("R1 count", rdData, 8'h00);
    regAddr = 1'b0;
    check("R1 irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic t_stab();
    wrReg(1'b1, 8'd5);
    regAddr = 1'b1; #0.1;
    check("R10 count readback", rdData, 8'd5);
    regAddr = 1'b0;
    cmpIn = 1'b1;
    waitCyc(3);
    wrReg(1'b0, 8'h01);
    waitCyc(4);
    check("R2 masked last cycle", {7'b0, resBit()}, 8'h00);
    waitCyc(1);
    check("R2 valid after count", {7'b0, resBit()}, 8'h01);
  endtask

  task automatic t_sync_pol();
    cmpIn = 1'b0;
    waitCyc(1);
    check("R3 one cycle old", {7'b0, resBit()}, 8'h01);
    waitCyc(1);
    check("R3 two cycles new", {7'b0, resBit()}, 8'h00);
    wrReg(1'b0, 8'h05);
    check("R4 inverted", {7'b0, resBit()}, 8'h01);
    wrReg(1'b0, 8'h01);
    check("R4 normal", {7'b0, resBit()}, 8'h00);
  endtask

  task automatic t_arm();
    wrReg(1'b0, 8'h03);
    cmpIn = 1'b1;
    waitCyc(4);
    check("R6 no irq before arming read", {7'b0, irqOut}, 8'h00);
    check("R6 no flag before arming read", {7'b0, flgBit()}, 8'h00);
    rdReg(1'b0);
    waitCyc(4);
    check("R5 steady after snapshot", {7'b0, irqOut}, 8'h00);
    cmpIn = 1'b0;
    waitCyc(4);
    check("R7 flag on change", {7'b0, flgBit()}, 8'h01);
    check("R7 irq on change", {7'b0, irqOut}, 8'h01);
  endtask

  task automatic t_clear();
    wrReg(1'b0, 8'h03);
    check("R8 clear without read ignored", {7'b0, flgBit()}, 8'h01);
    wrReg(1'b0, 8'h13);
    check("R8 write one ignored", {7'b0, flgBit()}, 8'h01);
    rdReg(1'b0);
    wrReg(1'b0, 8'h03);
    check("R8 cleared after read", {7'b0, flgBit()}, 8'h00);
    check("R8 irq low after clear", {7'b0, irqOut}, 8'h00);
    cmpIn = 1'b1;
    waitCyc(4);
    check("R7 re-armed other direction", {7'b0, irqOut}, 8'h01);
    rdReg(1'b0);
    wrReg(1'b0, 8'h03);
    check("R8 second clear", {7'b0, flgBit()}, 8'h00);
  endtask

  task automatic t_disarm();
    cmpIn = 1'b0;
    waitCyc(4);
    check("R9 irq before disable", {7'b0, irqOut}, 8'h01);
    wrReg(1'b0, 8'h11);
    check("R9 irq drops with enable", {7'b0, irqOut}, 8'h00);
    check("R9 flag kept", {7'b0, flgBit()}, 8'h01);
    wrReg(1'b0, 8'h13);
    waitCyc(2);
    check("R9 not armed until read", {7'b0, irqOut}, 8'h00);
    rdReg(1'b0);
    check("R9 armed by read", {7'b0, irqOut}, 8'h01);
    wrReg(1'b0, 8'h03);
    check("R8 clear after arming read", {7'b0, flgBit()}, 8'h00);
  endtask

  task automatic t_off();
    wrReg(1'b0, 8'h00);
    cmpIn = 1'b1;
    waitCyc(3);
    check("R10 off reads zero", {7'b0, resBit()}, 8'h00);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    t_reset();
    t_stab();
    t_sync_pol();
    t_arm();
    t_clear();
    t_disarm();
    t_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule